// File: doc/BRIEF.md
# Clock-Stop Power Mode Controller

This block decides when a small microcontroller core may enter a clock-stop low-power state, and when it leaves it. The instruction decoder sends a single-cycle stop strobe. A mode bit, loaded through a write strobe from a port-output instruction, selects between two policies. In the HOLD-gated policy the strobe only takes effect while the HOLD pin is low. In the unconditional policy it always takes effect.

While stopped, the block turns off the crystal oscillator enable and tells the output and display drivers to go low or off. It watches for a wake event: HOLD, or any port-1 pin configured as an input, moving away from the level it had at stop entry. When a wake event is seen, the oscillator is turned back on. The core stays halted for a fixed standby count of always-on clock cycles while the oscillator settles. The core then resumes at the next instruction with its internal state intact.

The logic runs from an always-on low-rate clock. HOLD and the port pins pass through two-flop synchronizers before any decision is made.

Top module: `cstop_ctrl`

## Requirements
- R1: After reset the state code is IDLE (0), and osc_en, pll_en and core_run are 1 while outs_off is 0.
- R2: With the mode bit at 0 and synchronized HOLD at 1, a stop request acts as a no-operation: the state stays IDLE and core_run stays 1.
- R3: With the mode bit at 0 and HOLD at 0, or with the mode bit at 1 and any HOLD level, a stop request seen at a clock edge makes the state STOPPED (code 1) right after that edge.
- R4: In STOPPED, osc_en and core_run are 0 and outs_off is 1.
- R5: pll_en is 0 in the cycle after any stop request taken in IDLE, whether or not the request is accepted. It stays 0 through STOPPED and STANDBY and is 1 again once the block is back in IDLE with no new request.
- R6: In STOPPED, a wake event comes from HOLD. With the mode bit at 0, a wake occurs when HOLD is high. With the mode bit at 1, a wake occurs when HOLD differs from its level at stop entry. The state turns STANDBY (code 2) three clock edges after the pin change: two for the synchronizer and one for the state register.
- R7: In STOPPED, a port pin whose direction bit is 0 (input) wakes the block when its level differs from the level captured at stop entry. The timing is the same three-edge latency as R6.
- R8: Level changes on port pins whose direction bit is 1 (output) never wake the block.
- R9: STANDBY lasts exactly STANDBY_CYCLES clock cycles and then returns to IDLE. During STANDBY, osc_en is 1, outs_off is 0 and core_run is 0.
- R10: A stop request that arrives in STOPPED or STANDBY is ignored. The state and the standby timing are unchanged.
- R11: The mode bit is loaded from mode_wr_val on a clock edge where mode_wr_en is 1, and it keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on low-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Single-cycle stop strobe from instruction decode |
| mode_wr_en | input | 1 | Write strobe for the mode bit |
| mode_wr_val | input | 1 | Mode value: 0 = HOLD-gated, 1 = unconditional |
| hold_pin | input | 1 | Asynchronous HOLD pin |
| port1_pin | input | NPINS | Asynchronous port-1 pin levels |
| port1_dir | input | NPINS | Direction per pin, 1 = output (masked from wake) |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| outs_off | output | 1 | Force output and display pins low/off |
| core_run | output | 1 | Core may execute |
| state_o | output | 2 | 0 = IDLE, 1 = STOPPED, 2 = STANDBY |

## Verification
The outputs have three distinct latencies:
- Entry into STOPPED, and the PLL drop, show one edge after the stop strobe is sampled.
- A pin or HOLD wake shows three edges after the pin moves.
- The return to IDLE shows exactly STANDBY_CYCLES edges after STANDBY begins.

The bench drives every input on a falling edge. After a wake stimulus it checks the state and all four enables on every falling edge that follows. Each intermediate cycle is therefore pinned: still STOPPED at offsets 1 and 2, STANDBY from offset 3, and IDLE exactly at offset 3 + STANDBY_CYCLES. An early or late transition fails at a named offset. The sweep covers both modes, both HOLD levels and all sixteen direction patterns.

// File: rtl/cstop_pkg.sv
package cstop_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_STOPPED = 2'd1,
      ST_STANDBY = 2'd2
   } cstop_state_e;
endpackage

// File: rtl/cstop_sync.sv
module cstop_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 2 && W >= 1) else $error("cstop_sync: bad parameters");

   logic [W-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cstop_wake_det.sv
module cstop_wake_det #(
   parameter int NPINS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic             mode,
   input  logic             hold_s,
   input  logic [NPINS-1:0] pins_s,
   input  logic [NPINS-1:0] dir,
   output logic             wake
);
   logic             snap_hold;
   logic [NPINS-1:0] snap_pins;
   logic             pin_evt;
   logic             hold_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_hold <= 1'b0;
         snap_pins <= '0;
      end else if (capture) begin
         snap_hold <= hold_s;
         snap_pins <= pins_s;
      end
   end

   // only input-configured pins (dir bit 0) take part
   assign pin_evt  = |((pins_s ^ snap_pins) & ~dir);
   // HOLD-gated policy wakes on high level, unconditional policy on any change
   assign hold_evt = mode ? (hold_s ^ snap_hold) : hold_s;
   assign wake     = pin_evt | hold_evt;
endmodule

// File: rtl/cstop_fsm.sv
module cstop_fsm
   import cstop_pkg::*;
#(
   parameter int STANDBY_CYCLES = 3277
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stop_req,
   input  logic         mode,
   input  logic         hold_s,
   input  logic         wake,
   output cstop_state_e state,
   output logic         capture,
   output logic         pll_en
);
   localparam int CNT_W = (STANDBY_CYCLES > 1) ? $clog2(STANDBY_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STANDBY_CYCLES - 1);

   initial assert (STANDBY_CYCLES >= 1) else $error("cstop_fsm: STANDBY_CYCLES must be >= 1");

   cstop_state_e     state_n;
   logic [CNT_W-1:0] cnt;
   logic             req_in_idle;

   assign req_in_idle = (state == ST_IDLE) && stop_req;
   assign capture     = req_in_idle && (mode || !hold_s);

   always_comb begin
      state_n = state;
      unique case (state)
         ST_IDLE:    if (capture) state_n = ST_STOPPED;
         ST_STOPPED: if (wake)    state_n = ST_STANDBY;
         ST_STANDBY: if (cnt == LAST) state_n = ST_IDLE;
         default:    state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         pll_en <= 1'b1;
      end else begin
         state  <= state_n;
         pll_en <= (state_n == ST_IDLE) && !req_in_idle;
         if (state == ST_STANDBY && cnt != LAST) cnt <= cnt + 1'b1;
         else                                    cnt <= '0;
      end
   end

   assert_noop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && stop_req && !mode && hold_s) |=> state == ST_IDLE);

   assert_enter_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && stop_req && mode) |=> state == ST_STOPPED);

   assert_pll_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && stop_req) |=> !pll_en);

   assert_stay_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOPPED && !wake) |=> state == ST_STOPPED);

   assert_standby_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STANDBY && cnt != LAST) |=> state == ST_STANDBY);

   assert_standby_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STOPPED && wake) |=> (state == ST_STANDBY && cnt == '0));
endmodule

// File: rtl/cstop_ctrl.sv
module cstop_ctrl
   import cstop_pkg::*;
#(
   parameter int NPINS          = 4,
   parameter int SYNC_STAGES    = 2,
   parameter int STANDBY_CYCLES = 3277
) (
   input  logic             clk_aon,
   input  logic             rst_n,
   input  logic             stop_req,
   input  logic             mode_wr_en,
   input  logic             mode_wr_val,
   input  logic             hold_pin,
   input  logic [NPINS-1:0] port1_pin,
   input  logic [NPINS-1:0] port1_dir,
   output logic             osc_en,
   output logic             pll_en,
   output logic             outs_off,
   output logic             core_run,
   output logic [1:0]       state_o
);
   localparam int SW = NPINS + 1;

   initial assert (NPINS >= 1) else $error("cstop_ctrl: NPINS must be >= 1");

   logic             mode_q;
   logic [SW-1:0]    sync_q;
   logic             hold_s;
   logic [NPINS-1:0] pins_s;
   logic             wake;
   logic             capture;
   cstop_state_e     state;

   always_ff @(posedge clk_aon or negedge rst_n) begin
      if (!rst_n)          mode_q <= 1'b0;
      else if (mode_wr_en) mode_q <= mode_wr_val;
   end

   cstop_sync #(.W(SW), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk_aon),
      .rst_n (rst_n),
      .d     ({hold_pin, port1_pin}),
      .q     (sync_q)
   );
   assign hold_s = sync_q[SW-1];
   assign pins_s = sync_q[NPINS-1:0];

   cstop_wake_det #(.NPINS(NPINS)) wake_i (
      .clk     (clk_aon),
      .rst_n   (rst_n),
      .capture (capture),
      .mode    (mode_q),
      .hold_s  (hold_s),
      .pins_s  (pins_s),
      .dir     (port1_dir),
      .wake    (wake)
   );

   cstop_fsm #(.STANDBY_CYCLES(STANDBY_CYCLES)) fsm_i (
      .clk      (clk_aon),
      .rst_n    (rst_n),
      .stop_req (stop_req),
      .mode     (mode_q),
      .hold_s   (hold_s),
      .wake     (wake),
      .state    (state),
      .capture  (capture),
      .pll_en   (pll_en)
   );

   assign osc_en   = (state != ST_STOPPED);
   assign outs_off = (state == ST_STOPPED);
   assign core_run = (state == ST_IDLE);
   assign state_o  = state;

   assert_mode_kept_R11: assert property (@(posedge clk_aon) disable iff (!rst_n)
      !mode_wr_en |=> $stable(mode_q));
endmodule

// File: tb/cstop_ctrl_tb_top.sv
module cstop_ctrl_tb_top;
   localparam int NP = 4;
   localparam int SB = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stop_req = 1'b0;
   logic          mode_wr_en = 1'b0;
   logic          mode_wr_val = 1'b0;
   logic          hold_pin = 1'b0;
   logic [NP-1:0] port1_pin = '0;
   logic [NP-1:0] port1_dir = '0;
   logic          osc_en, pll_en, outs_off, core_run;
   logic [1:0]    state_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   cstop_ctrl #(.NPINS(NP), .SYNC_STAGES(2), .STANDBY_CYCLES(SB)) dut_i (
      .clk_aon     (clk),
      .rst_n       (rst_n),
      .stop_req    (stop_req),
      .mode_wr_en  (mode_wr_en),
      .mode_wr_val (mode_wr_val),
      .hold_pin    (hold_pin),
      .port1_pin   (port1_pin),
      .port1_dir   (port1_dir),
      .osc_en      (osc_en),
      .pll_en      (pll_en),
      .outs_off    (outs_off),
      .core_run    (core_run),
      .state_o     (state_o)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // state 0 IDLE, 1 STOPPED, 2 STANDBY; expected enables derive from it
   task automatic chk_all(string tag, int exp_st, int exp_pll);
      chk({tag, " state"}, state_o, exp_st);
      chk({tag, " osc_en"}, osc_en, (exp_st != 1) ? 1 : 0);
      chk({tag, " outs_off"}, outs_off, (exp_st == 1) ? 1 : 0);
      chk({tag, " core_run"}, core_run, (exp_st == 0) ? 1 : 0);
      chk({tag, " pll_en"}, pll_en, exp_pll);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_all("R1 in reset", 0, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_all("R1 after reset", 0, 1);

      for (int m = 0; m < 2; m++) begin
         for (int h = 0; h < 2; h++) begin
            for (int d = 0; d < 16; d++) begin
               bit enter;
               int pin_i;
               // R11: mode bit loaded by strobe
               mode_wr_en = 1'b1; mode_wr_val = m[0];
               hold_pin = h[0]; port1_dir = NP'(d);
               @(negedge clk);
               mode_wr_en = 1'b0; mode_wr_val = ~m[0];
               repeat (3) @(negedge clk);

               enter = (m == 1) || (h == 0);
               stop_req = 1'b1;
               @(negedge clk);
               stop_req = 1'b0;
               if (!enter) begin
                  chk_all("R2 R5 noop request", 0, 0);
                  @(negedge clk);
                  chk_all("R2 R5 noop recovered", 0, 1);
                  continue;
               end
               chk_all("R3 R4 R5 entered stop", 1, 0);

               // R8 and R10: toggle output pins and repeat request while stopped
               port1_pin = port1_pin ^ NP'(d);
               stop_req = 1'b1;
               @(negedge clk);
               stop_req = 1'b0;
               repeat (4) @(negedge clk);
               chk_all("R8 R10 still stopped", 1, 0);

               if (d != 15) begin
                  pin_i = 0;
                  while (d[pin_i]) pin_i++;
                  port1_pin[pin_i] = ~port1_pin[pin_i];   // R7 input pin wake
               end else begin
                  hold_pin = ~hold_pin;                    // R6 HOLD wake
               end

               for (int k = 1; k <= 3 + SB; k++) begin
                  int exp_st;
                  @(negedge clk);
                  stop_req = (k == 4);                     // R10 request in standby
                  exp_st = (k < 3) ? 1 : ((k < 3 + SB) ? 2 : 0);
                  chk_all((d != 15) ? "R7 R9 R10 pin wake seq" : "R6 R9 R10 hold wake seq",
                          exp_st, (exp_st == 0) ? 1 : 0);
               end
               stop_req = 1'b0;
               @(negedge clk);
               chk_all("R9 back in idle", 0, 1);
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule